// File: doc/BRIEF.md
# Serial EEPROM Slave with Page Buffer and Region Lock

This block is the slave side of a byte-addressed serial memory reached over a four-wire SPI link (select, clock, data in, data out), plus a pause input and a write-protect input. All serial inputs are resynchronised into the system clock domain. The block accepts an instruction byte and, where one is needed, a two-byte address. It then streams array bytes out, returns its status byte, or collects write bytes into a page buffer. The array is a register array that resets to the erased value 0xFF.

A page write is committed when select is released on a whole-byte boundary. The block then enters a self-timed programming interval of `BUSY_CYCLES` system clocks. During that interval the status byte shows busy, and every instruction except the status read is ignored. A three-bit region selector keeps writes out of the first page, the last page, one chosen quarter, or the lower half. A lock flag combined with the write-protect pin freezes the status settings.

Top module: `spi_ee_slave`

## Requirements
- R1: After reset the status byte reads 0x00 and every array byte reads 0xFF.
- R2: Transfers work with clock idle low and with clock idle high. Data in is taken on the rising clock edge and data out changes after the falling edge, most significant bit first.
- R3: While the pause input is low, clock edges are ignored and `spi_miso_oe` is 0. The bit and byte position is kept, so the transfer continues unchanged when the pause input returns high.
- R4: The enable-write opcode 0x06 sets status bit 1. The disable opcode 0x04 clears it.
- R5: A write (0x02) or a status write (0x01) issued while status bit 1 is clear changes nothing.
- R6: A write is opcode 0x02, a two-byte address (high byte first), then data bytes. Releasing select on a byte boundary starts a programming interval of BUSY_CYCLES clocks. During it status bit 0 reads 1 and bit 1 stays set. Afterwards the bytes are in the array and both bits read 0.
- R7: Write data that runs past the end of a page wraps to the start of the same page. A page is 16 bytes for depths of 256 or 512 and 32 bytes otherwise.
- R8: A read (0x03 plus a two-byte address) returns consecutive bytes from the given address and wraps from the top address to 0.
- R9: A write whose select is released in the middle of a byte is discarded. Status bit 1 stays set.
- R10: Status bits [4:2] pick the locked region: 0 none, 1 first page, 2 last page, 3..6 quarters 0..3, 7 lower half. A write that touches any locked byte is discarded as a whole and leaves status bit 1 set.
- R11: The status write (0x01 plus one byte) loads bits [4:2] and the lock flag in bit 7, and it clears bit 1. When bit 7 is 1 and the write-protect input is low, a status write is ignored and bit 1 stays set.
- R12: While busy, every instruction other than the status read (0x05) is ignored and drives no data out.
- R13: `spi_miso_oe` is 1 only during the data phase of a read or a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_hold_n | input | 1 | Pause input, active low |
| spi_wp_n | input | 1 | Write-protect input, active low |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for spi_miso |

## Verification
The bench writes past the end of a page and checks the bytes at the start of that page. A design that carried the address into the next page would leave those bytes at 0xFF and corrupt the next page. It pauses a read in the middle of a byte and clocks the line while paused; a design that counted those edges would return a shifted byte. It releases select after three bits of a data byte and issues instructions while busy; a design that got either wrong would change array contents or let the enable-write latch drop. It also covers each region code and the hardware lock, where a wrong decode either writes into a locked page or refuses a legal one.

// File: rtl/spi_ee_pkg.sv
// Shared opcodes, protocol states and geometry helpers for the serial EEPROM slave.
package spi_ee_pkg;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    typedef enum logic [2:0] {
        ST_CMD, ST_ADDR_HI, ST_ADDR_LO, ST_READ,
        ST_WDATA, ST_SRW, ST_RDSR, ST_SKIP
    } ee_state_t;

    // Page size follows the array depth: small arrays use 16-byte pages.
    function automatic int page_bytes(input int depth);
        return (depth <= 512) ? 16 : 32;
    endfunction
endpackage

// File: rtl/spi_ee_frontend.sv
// Serial front end: brings the asynchronous pins into the clk domain with
// two flops and turns clock transitions into one-cycle pulses.
// Assumes the serial clock runs well below a quarter of clk.
module spi_ee_frontend (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    input  logic hold_n,
    input  logic wp_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s,
    output logic sel,
    output logic held,
    output logic desel_edge,
    output logic wp_low
);
    localparam int NSIG = 5;
    // order: {cs_n, hold_n, wp_n, sck, mosi}
    localparam logic [NSIG-1:0] IDLE = 5'b11100;

    logic [NSIG-1:0] s1, s2;
    logic            sck_q, cs_q;

    // two-stage synchroniser for every serial pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= IDLE;
            s2 <= IDLE;
        end else begin
            s1 <= {cs_n, hold_n, wp_n, sck, mosi};
            s2 <= s1;
        end
    end

    // previous levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= s2[1];
            cs_q  <= s2[4];
        end
    end

    assign mosi_s     = s2[0];
    assign sel        = ~s2[4];
    assign held       = sel & ~s2[3];
    assign wp_low     = ~s2[2];
    assign sck_rise   = sel & s2[3] & s2[1] & ~sck_q;
    assign sck_fall   = sel & s2[3] & ~s2[1] & sck_q;
    assign desel_edge = s2[4] & ~cs_q;
endmodule

// File: rtl/spi_ee_timer.sv
// Self-timed programming interval: busy stays high for CYCLES clocks after
// start, then done pulses for one clock. Start is ignored while busy.
module spi_ee_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt;

    // interval counter and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
            cnt  <= '0;
        end else begin
            done <= 1'b0;
            if (busy) begin
                if (cnt == CW'(CYCLES - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end else if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end
    end

    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(cnt) < CYCLES));
    a_r6_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cnt == '0));
endmodule

// File: rtl/spi_ee_protect.sv
// Region decoder: flags an address that falls inside the region chosen by
// the 3-bit selector (0 none, 1 first page, 2 last page, 3..6 quarters, 7 lower half).
module spi_ee_protect #(
    parameter int DEPTH = 256,
    parameter int PAGE  = 16
) (
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic [2:0]               region,
    output logic                     hit
);
    localparam int AW = $clog2(DEPTH);

    // combinational region compare
    always_comb begin
        case (region)
            3'd0:    hit = 1'b0;
            3'd1:    hit = (int'(addr) < PAGE);
            3'd2:    hit = (int'(addr) >= DEPTH - PAGE);
            3'd7:    hit = ~addr[AW-1];
            default: hit = (addr[AW-1:AW-2] == (region[1:0] + 2'd1));
        endcase
    end
endmodule

// File: rtl/spi_ee_array.sv
// Storage: byte array with a page buffer and per-byte valid flags. Staged
// bytes are copied into their page on commit. The array resets to 0xFF.
module spi_ee_array #(
    parameter int DEPTH = 256,
    parameter int PAGE  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [$clog2(DEPTH)-1:0]    rd_addr,
    output logic [7:0]                  rd_data,
    input  logic                        clr,
    input  logic                        stg_we,
    input  logic [$clog2(PAGE)-1:0]     stg_idx,
    input  logic [7:0]                  stg_data,
    input  logic [$clog2(DEPTH/PAGE)-1:0] stg_page,
    input  logic                        commit
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = $clog2(PAGE);
    localparam int NW = AW - PW;

    logic [7:0]    mem [DEPTH];
    logic [7:0]    pbuf [PAGE];
    logic [PAGE-1:0] vld;
    logic [NW-1:0] base;

    assign rd_data = mem[rd_addr];

    // array update on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < PAGE; i++)
                if (vld[i]) mem[{base, PW'(i)}] <= pbuf[i];
        end
    end

    // page buffer staging
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= '0;
            base <= '0;
            for (int i = 0; i < PAGE; i++) pbuf[i] <= 8'h00;
        end else if (clr) begin
            vld <= '0;
        end else if (stg_we) begin
            pbuf[stg_idx] <= stg_data;
            vld[stg_idx]  <= 1'b1;
            base          <= stg_page;
        end
    end
endmodule

// File: rtl/spi_ee_slave.sv
// Serial EEPROM slave top: decodes instructions, addresses and data bytes,
// drives read data, owns the status flags and starts the programming timer.
// Assumes clk is at least 8x faster than the serial clock.
module spi_ee_slave
    import spi_ee_pkg::*;
#(
    parameter int DEPTH       = 256,
    parameter int BUSY_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    input  logic spi_hold_n,
    input  logic spi_wp_n,
    output logic spi_miso,
    output logic spi_miso_oe
);
    localparam int AW   = $clog2(DEPTH);
    localparam int PAGE = page_bytes(DEPTH);
    localparam int PW   = $clog2(PAGE);

    logic sck_rise, sck_fall, mosi_s, sel, held, desel_edge, wp_low;
    logic busy, done, start, prot_hit;
    logic [7:0] rd_data, rx_byte, tx_byte, out_sh, st_byte;
    logic [6:0] shreg;
    logic [2:0] bitcnt, bp, sr_bp;
    logic [7:0] addr_hi;
    logic [AW-1:0] addr, new_addr, rd_addr;
    ee_state_t state;
    logic is_rd, got, bad, wel, wpen, sr_wpen, tx_pend, oe_q, byte_done;

    spi_ee_frontend i_front (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .cs_n(spi_cs_n),
        .mosi(spi_mosi), .hold_n(spi_hold_n), .wp_n(spi_wp_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
        .sel(sel), .held(held), .desel_edge(desel_edge), .wp_low(wp_low)
    );

    spi_ee_timer #(.CYCLES(BUSY_CYCLES)) i_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
    );

    spi_ee_protect #(.DEPTH(DEPTH), .PAGE(PAGE)) i_prot (
        .addr(addr), .region(bp), .hit(prot_hit)
    );

    spi_ee_array #(.DEPTH(DEPTH), .PAGE(PAGE)) i_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .clr(byte_done && state == ST_ADDR_LO && !is_rd),
        .stg_we(byte_done && state == ST_WDATA),
        .stg_idx(addr[PW-1:0]), .stg_data(rx_byte),
        .stg_page(addr[AW-1:PW]), .commit(done)
    );

    assign rx_byte   = {shreg, mosi_s};
    assign byte_done = sck_rise && (bitcnt == 3'd7);
    assign new_addr  = AW'({addr_hi, rx_byte});
    assign rd_addr   = (state == ST_ADDR_LO) ? new_addr : addr;
    assign st_byte   = {wpen, 2'b00, bp, wel, busy};
    assign start     = desel_edge && state == ST_WDATA && got && bitcnt == 3'd0
                       && !bad && !busy;
    assign spi_miso    = out_sh[7];
    assign spi_miso_oe = oe_q & sel & ~held;

    // protocol sequencing, status flags and output shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_CMD;  bitcnt <= '0;  shreg <= '0;  addr_hi <= '0;
            addr <= '0;  is_rd <= 1'b0;  got <= 1'b0;  bad <= 1'b0;
            wel <= 1'b0;  bp <= '0;  wpen <= 1'b0;  sr_bp <= '0;
            sr_wpen <= 1'b0;  tx_byte <= '0;  tx_pend <= 1'b0;
            out_sh <= 8'hFF;  oe_q <= 1'b0;
        end else begin
            if (desel_edge && state == ST_SRW && got && bitcnt == 3'd0
                && !(wpen && wp_low)) begin
                bp   <= sr_bp;
                wpen <= sr_wpen;
                wel  <= 1'b0;
            end
            if (!sel) begin
                state <= ST_CMD;  bitcnt <= '0;  got <= 1'b0;  bad <= 1'b0;
                tx_pend <= 1'b0;  oe_q <= 1'b0;
            end else begin
                if (sck_rise) begin
                    shreg  <= rx_byte[6:0];
                    bitcnt <= bitcnt + 3'd1;
                end
                if (byte_done) begin
                    case (state)
                        ST_CMD: begin
                            state <= ST_SKIP;
                            if (rx_byte == OP_RDSR) begin
                                tx_byte <= st_byte;  tx_pend <= 1'b1;  state <= ST_RDSR;
                            end else if (!busy) begin
                                case (rx_byte)
                                    OP_WREN:  wel <= 1'b1;
                                    OP_WRDI:  wel <= 1'b0;
                                    OP_WRSR:  if (wel) state <= ST_SRW;
                                    OP_READ:  begin is_rd <= 1'b1; state <= ST_ADDR_HI; end
                                    OP_WRITE: if (wel) begin is_rd <= 1'b0; state <= ST_ADDR_HI; end
                                    default: ;
                                endcase
                            end
                        end
                        ST_ADDR_HI: begin
                            addr_hi <= rx_byte;
                            state   <= ST_ADDR_LO;
                        end
                        ST_ADDR_LO: begin
                            if (is_rd) begin
                                tx_byte <= rd_data;  tx_pend <= 1'b1;
                                addr    <= new_addr + AW'(1);
                                state   <= ST_READ;
                            end else begin
                                addr  <= new_addr;
                                state <= ST_WDATA;
                            end
                        end
                        ST_READ: begin
                            tx_byte <= rd_data;  tx_pend <= 1'b1;
                            addr    <= addr + AW'(1);
                        end
                        ST_WDATA: begin
                            got  <= 1'b1;
                            bad  <= bad | prot_hit;
                            addr <= {addr[AW-1:PW], addr[PW-1:0] + PW'(1)};
                        end
                        ST_SRW: if (!got) begin
                            sr_bp   <= rx_byte[4:2];
                            sr_wpen <= rx_byte[7];
                            got     <= 1'b1;
                        end
                        ST_RDSR: begin
                            tx_byte <= st_byte;  tx_pend <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                if (sck_fall) begin
                    if (tx_pend) begin
                        out_sh  <= tx_byte;
                        tx_pend <= 1'b0;
                        oe_q    <= 1'b1;
                    end else begin
                        out_sh <= {out_sh[6:0], 1'b1};
                    end
                end
            end
            if (done) wel <= 1'b0;
        end
    end

    a_r12_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state == ST_CMD || state == ST_RDSR || state == ST_SKIP));
    a_r6_wel_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> wel);
    a_r6_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wel);
    a_r3_hold_keeps_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && held) |=> $stable(bitcnt));
    a_r13_oe_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> $past(sck_fall));
endmodule

// File: tb/test_spi_ee_slave.sv
// Directed bench: one task per scenario, each checking its own results.
module test_spi_ee_slave;
    localparam int H    = 6;
    localparam int BUSY = 1500;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic miso, oe, oe_seen;
    bit   mode3 = 1'b0;
    int   errs = 0, checks = 0;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    always #2 clk = ~clk;

    spi_ee_slave #(.DEPTH(256), .BUSY_CYCLES(BUSY)) i_spi_ee_slave (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_hold_n(hold_n), .spi_wp_n(wp_n),
        .spi_miso(miso), .spi_miso_oe(oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    task automatic cs_on();
        sck = mode3;  tick(H);  cs_n = 1'b0;  tick(H);
    endtask

    task automatic cs_off();
        tick(H);  cs_n = 1'b1;  tick(2 * H);
    endtask

    task automatic bitx(input logic b, output logic r);
        if (mode3) sck = 1'b0;
        mosi = b;  tick(H);
        r = miso;  oe_seen = oe;
        sck = 1'b1;  tick(H);
        if (!mode3) begin sck = 1'b0; tick(H); end
    endtask

    task automatic xbyte_h(input logic [7:0] tx, output logic [7:0] rx, input int hold_at);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            if (i == hold_at) begin
                hold_n = 1'b0;  tick(4);
                for (int k = 0; k < 3; k++) begin
                    sck = ~sck;  tick(H);  sck = ~sck;  tick(H);
                end
                chk("R3 oe low while paused", {7'b0, oe}, 8'h00);
                hold_n = 1'b1;  tick(4);
            end
            bitx(tx[i], r);
            rx[i] = r;
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        xbyte_h(tx, rx, -1);
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        cs_on();  xbyte(op, d);  cs_off();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        cs_on();  xbyte(8'h05, d);
        chk("R13 oe low during opcode", {7'b0, oe_seen}, 8'h00);
        xbyte(8'h00, s);
        chk("R13 oe high during status data", {7'b0, oe_seen}, 8'h01);
        cs_off();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        cs_on();  xbyte(8'h01, d);  xbyte(v, d);  cs_off();
    endtask

    task automatic wr(input logic [7:0] a, input int n);
        logic [7:0] d;
        cs_on();  xbyte(8'h02, d);  xbyte(8'h00, d);  xbyte(a, d);
        for (int i = 0; i < n; i++) xbyte(wbuf[i], d);
        cs_off();
    endtask

    task automatic rd(input logic [7:0] a, input int n);
        logic [7:0] d;
        cs_on();  xbyte(8'h03, d);  xbyte(8'h00, d);  xbyte(a, d);
        for (int i = 0; i < n; i++) xbyte(8'h00, rbuf[i]);
        cs_off();
    endtask

    task automatic wait_done();
        tick(BUSY + 100);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R13 oe idle", {7'b0, oe}, 8'h00);
        rdsr(s);  chk("R1 status after reset", s, 8'h00);
        rd(8'h00, 1);  chk("R1 erased byte", rbuf[0], 8'hFF);
        rd(8'hC7, 1);  chk("R1 erased byte high", rbuf[0], 8'hFF);
    endtask

    task automatic t_latch_mode3();
        logic [7:0] s;
        mode3 = 1'b1;
        cmd1(8'h06);  rdsr(s);  chk("R4 R2 enable latch set", s, 8'h02);
        cmd1(8'h04);  rdsr(s);  chk("R4 R2 enable latch cleared", s, 8'h00);
        mode3 = 1'b0;
    endtask

    task automatic t_no_wel();
        logic [7:0] s;
        wbuf[0] = 8'hAA;  wr(8'h10, 1);
        rdsr(s);  chk("R5 no busy without latch", s, 8'h00);
        rd(8'h10, 1);  chk("R5 byte untouched", rbuf[0], 8'hFF);
        wrsr(8'h1C);  rdsr(s);  chk("R5 status write refused", s, 8'h00);
    endtask

    task automatic t_page();
        logic [7:0] s;
        cmd1(8'h06);
        wbuf[0] = 8'h11;  wbuf[1] = 8'h22;  wbuf[2] = 8'h33;
        wr(8'h00, 3);
        rdsr(s);  chk("R6 busy with latch", s, 8'h03);
        wait_done();
        rdsr(s);  chk("R6 idle after interval", s, 8'h00);
        rd(8'h00, 3);
        chk("R6 byte 0", rbuf[0], 8'h11);
        chk("R6 byte 1", rbuf[1], 8'h22);
        chk("R6 byte 2", rbuf[2], 8'h33);
    endtask

    task automatic t_wrap();
        cmd1(8'h06);
        wbuf[0] = 8'hA0;  wbuf[1] = 8'hA1;  wbuf[2] = 8'hA2;  wbuf[3] = 8'hA3;
        wr(8'h3E, 4);  wait_done();
        rd(8'h3E, 2);
        chk("R7 page tail 0", rbuf[0], 8'hA0);
        chk("R7 page tail 1", rbuf[1], 8'hA1);
        rd(8'h30, 3);
        chk("R7 wrapped 0", rbuf[0], 8'hA2);
        chk("R7 wrapped 1", rbuf[1], 8'hA3);
        chk("R7 untouched", rbuf[2], 8'hFF);
        rd(8'h40, 1);  chk("R7 next page clean", rbuf[0], 8'hFF);
    endtask

    task automatic t_read_wrap();
        cmd1(8'h06);  wbuf[0] = 8'h5A;  wr(8'hFF, 1);  wait_done();
        rd(8'hFF, 3);
        chk("R8 top byte", rbuf[0], 8'h5A);
        chk("R8 wrap to 0", rbuf[1], 8'h11);
        chk("R8 then 1", rbuf[2], 8'h22);
    endtask

    task automatic t_mode3_read();
        mode3 = 1'b1;  rd(8'h01, 2);  mode3 = 1'b0;
        chk("R2 idle-high read 0", rbuf[0], 8'h22);
        chk("R2 idle-high read 1", rbuf[1], 8'h33);
    endtask

    task automatic t_midbyte();
        logic [7:0] d, s;
        logic r;
        cmd1(8'h06);
        cs_on();  xbyte(8'h02, d);  xbyte(8'h00, d);  xbyte(8'h40, d);
        xbyte(8'hC3, d);
        for (int i = 0; i < 3; i++) bitx(1'b0, r);
        cs_off();
        rdsr(s);  chk("R9 no busy, latch kept", s, 8'h02);
        rd(8'h40, 1);  chk("R9 byte untouched", rbuf[0], 8'hFF);
        cmd1(8'h04);
    endtask

    task automatic t_protect();
        logic [7:0] s;
        cmd1(8'h06);  wrsr(8'h04);
        rdsr(s);  chk("R11 region 1 loaded, latch cleared", s, 8'h04);
        cmd1(8'h06);  wbuf[0] = 8'h77;  wr(8'h05, 1);
        rdsr(s);  chk("R10 first page refused", s, 8'h06);
        rd(8'h05, 1);  chk("R10 first page byte", rbuf[0], 8'hFF);
        wbuf[0] = 8'h66;  wr(8'h50, 1);
        rdsr(s);  chk("R10 open page accepted", s, 8'h07);
        wait_done();
        rd(8'h50, 1);  chk("R10 open page byte", rbuf[0], 8'h66);
        cmd1(8'h06);  wrsr(8'h08);
        cmd1(8'h06);  wbuf[0] = 8'h44;  wr(8'hF5, 1);
        rd(8'hF5, 1);  chk("R10 last page refused", rbuf[0], 8'hFF);
        cmd1(8'h04);
        cmd1(8'h06);  wrsr(8'h1C);
        cmd1(8'h06);  wbuf[0] = 8'h55;  wbuf[1] = 8'h56;  wr(8'h7E, 2);
        rd(8'h7E, 1);  chk("R10 lower half refused", rbuf[0], 8'hFF);
        wbuf[0] = 8'h88;  wr(8'h80, 1);  wait_done();
        rd(8'h80, 1);  chk("R10 upper half accepted", rbuf[0], 8'h88);
        cmd1(8'h06);  wrsr(8'h10);
        cmd1(8'h06);  wbuf[0] = 8'h12;  wr(8'h45, 1);
        rd(8'h45, 1);  chk("R10 quarter 1 refused", rbuf[0], 8'hFF);
        wbuf[0] = 8'h99;  wr(8'h85, 1);  wait_done();
        rd(8'h85, 1);  chk("R10 quarter 2 accepted", rbuf[0], 8'h99);
        cmd1(8'h06);  wrsr(8'h00);
        rdsr(s);  chk("R10 region cleared", s, 8'h00);
    endtask

    task automatic t_lock();
        logic [7:0] s;
        cmd1(8'h06);  wrsr(8'h80);
        rdsr(s);  chk("R11 lock flag set", s, 8'h80);
        wp_n = 1'b0;
        cmd1(8'h06);  wrsr(8'h04);
        rdsr(s);  chk("R11 locked status write ignored", s, 8'h82);
        wp_n = 1'b1;
        wrsr(8'h00);
        rdsr(s);  chk("R11 unlocked status write", s, 8'h00);
    endtask

    task automatic t_busy();
        logic [7:0] d, s;
        cmd1(8'h06);  wbuf[0] = 8'h9C;  wr(8'h60, 1);
        cmd1(8'h04);
        cs_on();  xbyte(8'h03, d);  xbyte(8'h00, d);  xbyte(8'h60, d);  xbyte(8'h00, d);
        cs_off();
        chk("R12 read while busy drives nothing", {7'b0, oe_seen}, 8'h00);
        rdsr(s);  chk("R12 disable ignored while busy", s, 8'h03);
        wait_done();
        rdsr(s);  chk("R12 done", s, 8'h00);
        rd(8'h60, 1);  chk("R12 data committed", rbuf[0], 8'h9C);
    endtask

    task automatic t_hold();
        logic [7:0] d;
        cs_on();  xbyte(8'h03, d);  xbyte(8'h00, d);  xbyte(8'h00, d);
        xbyte_h(8'h00, d, 4);  chk("R3 paused byte intact", d, 8'h11);
        xbyte(8'h00, d);       chk("R3 next byte after pause", d, 8'h22);
        cs_off();
    endtask

    initial begin
        tick(150000);
        errs++;  checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        tick(5);  rst_n = 1'b1;  tick(5);
        t_reset();
        t_latch_mode3();
        t_no_wel();
        t_page();
        t_wrap();
        t_read_wrap();
        t_mode3_read();
        t_midbyte();
        t_protect();
        t_lock();
        t_busy();
        t_hold();
        summary();
    end
endmodule